// File: doc/BRIEF.md
# Dual-Compare Up-Counter with Gated Clear

This block is a free-running up-counter that advances by one on each count tick while a run enable is high. Two compare registers watch the counter. Each has its own match detector, and each detector raises a one-cycle match pulse and then a one-cycle interrupt pulse. The first comparator only reports its match. The second comparator also sets the point at which the counter returns to zero, and a clear-enable control bit can switch that return off.

Software programs the two compare values and the clear-enable bit through a simple write port. The counter value is visible at all times. A typical use is a periodic time base: the second compare value sets the period, and the first one marks a point inside each period. With the clear disabled, the counter runs over the whole 16-bit range and both comparators act as plain event markers.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset the counter, both match pulses and both interrupts are 0. Both compare registers hold 0xFFFF, and clear-enable is 1.
- R2: While run_en is high, the counter goes up by exactly one on the clock edge where cnt_tick is high and keeps its value on any edge where cnt_tick is low.
- R3: While run_en is low, the counter is forced to 0 on the next edge and no match pulse is raised, whatever cnt_tick does.
- R4: match_o[0] is high for exactly the one clock after the counter has stepped to the value of compare register 0. It does not repeat while the counter stalls at that value.
- R5: match_o[1] behaves the same way for compare register 1, and it still fires when clear-enable is 0.
- R6: irq_o[i] equals match_o[i] delayed by one clock.
- R7: When clear-enable is 1 and the counter holds the value of compare register 1, the next tick loads 0 instead of incrementing. If compare register 0 is 0, that load raises match_o[0].
- R8: Reaching the value of compare register 0 never clears the counter; the next tick gives that value plus one.
- R9: With clear-enable 0, the counter counts past the value of compare register 1.
- R10: When the counter is not cleared, it wraps from 0xFFFF to 0x0000 on a tick.
- R11: The write port decodes the address as follows: address 0 writes compare register 0, address 1 writes compare register 1, and address 2 writes clear-enable from wr_data bit 0. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_en | input | 1 | Run enable; low holds the counter at zero |
| cnt_tick | input | 1 | Count-enable tick, one clock wide per step |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address (0, 1: compare, 2: control) |
| wr_data | input | 16 | Register write data |
| count_o | output | 16 | Current counter value |
| match_o | output | 2 | One-clock match pulses, bit i for compare register i |
| irq_o | output | 2 | Interrupt pulses, one clock after the matching match pulse |

## Verification
The properties assume that cnt_tick, run_en and the write port change only between clock edges and are never X once reset is released. They also assume that rst_n is held low for at least one edge at start-up. The properties do not depend on how often ticks arrive or on compare writes landing in the same cycle as a tick, because each one judges the next counter value from the compare and control state of the current cycle. The stimulus drives every input on the falling edge and waits out the reset synchronizer before its first step. It includes runs with back-to-back ticks, stalls, run drops and mid-run writes, so the assumptions hold on every path it takes.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  // Default geometry of the dual-compare counter
  localparam int unsigned DCC_CNT_W   = 16;
  localparam int unsigned DCC_NUM_CMP = 2;
  // Control word layout
  localparam int unsigned DCC_CLR_EN_BIT = 0;

  // Per-comparator reset-state record
  typedef struct packed {
    logic match;
    logic irq;
  } dcc_evt_t;
endpackage

// File: rtl/dcc_rst_sync.sv
module dcc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dcc_regs.sv
module dcc_regs
  import dcc_pkg::*;
#(
  parameter int unsigned        CNT_W   = DCC_CNT_W,
  parameter int unsigned        NUM_CMP = DCC_NUM_CMP,
  parameter int unsigned        ADDR_W  = $clog2(NUM_CMP + 1),
  parameter logic [CNT_W-1:0]   CMP_RST = '1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [CNT_W-1:0]                wr_data,
  output logic [NUM_CMP-1:0][CNT_W-1:0]   cmp_o,
  output logic                            clr_en_o
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_CMP);

  logic [NUM_CMP-1:0][CNT_W-1:0] cmp_q;
  logic [NUM_CMP-1:0][CNT_W-1:0] cmp_d;
  logic                          clr_en_q;
  logic                          clr_en_d;

  for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_cmp
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(gi);
    logic sel;

    always_comb begin
      sel       = wr_en && (wr_addr == MY_ADDR);
      cmp_d[gi] = sel ? wr_data : cmp_q[gi];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmp_q[gi] <= CMP_RST;
      else        cmp_q[gi] <= cmp_d[gi];
    end
  end

  always_comb begin
    clr_en_d = clr_en_q;
    if (wr_en && (wr_addr == CTRL_ADDR)) clr_en_d = wr_data[DCC_CLR_EN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clr_en_q <= 1'b1;
    else        clr_en_q <= clr_en_d;
  end

  assign cmp_o    = cmp_q;
  assign clr_en_o = clr_en_q;
endmodule

// File: rtl/dcc_counter.sv
module dcc_counter
  import dcc_pkg::*;
#(
  parameter int unsigned CNT_W = DCC_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             cnt_tick,
  input  logic             clr_req,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             adv_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             adv;

  always_comb begin
    adv   = run_en && cnt_tick;
    cnt_d = cnt_q;
    if (!run_en)      cnt_d = '0;
    else if (adv)     cnt_d = clr_req ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_d;
  assign adv_o     = adv;
endmodule

// File: rtl/dcc_match.sv
module dcc_match
  import dcc_pkg::*;
#(
  parameter int unsigned CNT_W = DCC_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] cmp_val,
  output logic             match_o,
  output logic             irq_o
);
  dcc_evt_t evt_q;
  dcc_evt_t evt_d;

  // An event exists only when the counter steps onto the compare value
  always_comb begin
    evt_d.match = adv && (cnt_nxt == cmp_val);
    evt_d.irq   = evt_q.match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_d;
  end

  assign match_o = evt_q.match;
  assign irq_o   = evt_q.irq;
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import dcc_pkg::*;
#(
  parameter int unsigned CNT_W   = DCC_CNT_W,
  parameter int unsigned NUM_CMP = DCC_NUM_CMP,
  parameter int unsigned ADDR_W  = $clog2(NUM_CMP + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_en,
  input  logic               cnt_tick,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [CNT_W-1:0]   wr_data,
  output logic [CNT_W-1:0]   count_o,
  output logic [NUM_CMP-1:0] match_o,
  output logic [NUM_CMP-1:0] irq_o
);
  // The last comparator is the one allowed to clear the counter
  localparam int unsigned CLR_IDX = NUM_CMP - 1;

  logic                          rst_sync_n;
  logic [NUM_CMP-1:0][CNT_W-1:0] cmp_q;
  logic                          clr_en_q;
  logic [CNT_W-1:0]              cnt;
  logic [CNT_W-1:0]              cnt_nxt;
  logic                          adv;
  logic                          clr_req;

  dcc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dcc_regs #(
    .CNT_W   (CNT_W),
    .NUM_CMP (NUM_CMP),
    .ADDR_W  (ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .cmp_o    (cmp_q),
    .clr_en_o (clr_en_q)
  );

  always_comb begin
    clr_req = clr_en_q && (cnt == cmp_q[CLR_IDX]);
  end

  dcc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .run_en    (run_en),
    .cnt_tick  (cnt_tick),
    .clr_req   (clr_req),
    .cnt_o     (cnt),
    .cnt_nxt_o (cnt_nxt),
    .adv_o     (adv)
  );

  for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_match
    dcc_match #(.CNT_W(CNT_W)) u_match (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .adv     (adv),
      .cnt_nxt (cnt_nxt),
      .cmp_val (cmp_q[gi]),
      .match_o (match_o[gi]),
      .irq_o   (irq_o[gi])
    );
  end

  assign count_o = cnt;
endmodule

// File: rtl/dual_cmp_timer_chk.sv
module dual_cmp_timer_chk #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_CMP = 2
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          run_en,
  input logic                          cnt_tick,
  input logic [CNT_W-1:0]              count,
  input logic [NUM_CMP-1:0]            match,
  input logic [NUM_CMP-1:0]            irq,
  input logic [NUM_CMP-1:0][CNT_W-1:0] cmp,
  input logic                          clr_en
);
  localparam int unsigned CLR_IDX = NUM_CMP - 1;

  assert_run_low_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (count == '0) && (match == '0));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !cnt_tick) |=> (count == $past(count)) && (match == '0));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && cnt_tick && !(clr_en && (count == cmp[CLR_IDX])))
      |=> (count == CNT_W'($past(count) + CNT_W'(1))));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && cnt_tick && clr_en && (count == cmp[CLR_IDX])) |=> (count == '0));

  for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_chk
    assert_irq_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq[gi] == $past(match[gi])));

    // R4 / R5: a pulse is only seen when the counter sits on that compare value
    assert_match_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
      match[gi] |-> (count == $past(cmp[gi])) || (count == cmp[gi]));
  end
endmodule

bind dual_cmp_timer dual_cmp_timer_chk #(
  .CNT_W   (CNT_W),
  .NUM_CMP (NUM_CMP)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .run_en   (run_en),
  .cnt_tick (cnt_tick),
  .count    (count_o),
  .match    (match_o),
  .irq      (irq_o),
  .cmp      (cmp_q),
  .clr_en   (clr_en_q)
);

// File: tb/tb_dual_cmp_timer.sv
`timescale 1ns/1ps
module tb_dual_cmp_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        run_en;
  logic        cnt_tick;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data;
  logic [15:0] count_o;
  logic [1:0]  match_o;
  logic [1:0]  irq_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  dual_cmp_timer dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cnt_tick(cnt_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count_o(count_o), .match_o(match_o), .irq_o(irq_o)
  );

  typedef struct packed {
    logic        tick;
    logic        run;
    logic [15:0] cnt;
    logic [1:0]  m;
  } vec_t;

  // compare 0 = 3, compare 1 = 5, clear enabled
  localparam vec_t VEC [13] = '{
    '{1'b1, 1'b1, 16'd1, 2'b00},
    '{1'b1, 1'b1, 16'd2, 2'b00},
    '{1'b1, 1'b1, 16'd3, 2'b01},
    '{1'b0, 1'b1, 16'd3, 2'b00},
    '{1'b1, 1'b1, 16'd4, 2'b00},
    '{1'b1, 1'b1, 16'd5, 2'b10},
    '{1'b0, 1'b1, 16'd5, 2'b00},
    '{1'b1, 1'b1, 16'd0, 2'b00},
    '{1'b1, 1'b1, 16'd1, 2'b00},
    '{1'b1, 1'b0, 16'd0, 2'b00},
    '{1'b1, 1'b1, 16'd1, 2'b00},
    '{1'b1, 1'b1, 16'd2, 2'b00},
    '{1'b1, 1'b1, 16'd3, 2'b01}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic r);
    @(negedge clk);
    cnt_tick = t;
    run_en   = r;
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cnt_tick = 1'b0;
    wr_en    = 1'b1;
    wr_addr  = a;
    wr_data  = d;
    @(negedge clk);
    wr_en    = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n    = 1'b0;
    cnt_tick = 1'b0;
    run_en   = 1'b1;
    wr_en    = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; run_en = 1'b0; cnt_tick = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;

    // R1: reset state
    do_reset();
    check("R1 count", 32'(count_o), 32'd0);
    check("R1 match", 32'(match_o), 32'd0);
    check("R1 irq",   32'(irq_o),   32'd0);

    // Table walk: R2 R3 R4 R5 R6 R7 R8
    wr(2'd0, 16'd3);
    wr(2'd1, 16'd5);
    begin
      logic [1:0] prev_m;
      prev_m = 2'b00;
      foreach (VEC[i]) begin
        step(VEC[i].tick, VEC[i].run);
        check($sformatf("R2/R3/R7/R8 vec%0d count", i), 32'(count_o), 32'(VEC[i].cnt));
        check($sformatf("R4/R5 vec%0d match", i), 32'(match_o), 32'(VEC[i].m));
        check($sformatf("R6 vec%0d irq", i), 32'(irq_o), 32'(prev_m));
        prev_m = VEC[i].m;
      end
    end

    // R3: run low with ticks gives no pulse and holds zero
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    check("R3 count held zero", 32'(count_o), 32'd0);
    check("R3 no match", 32'(match_o), 32'd0);

    // R9: clear disabled counts past compare 1, match 1 still fires
    do_reset();
    wr(2'd2, 16'd0);
    wr(2'd0, 16'd100);
    wr(2'd1, 16'd5);
    for (int k = 0; k < 5; k++) step(1'b1, 1'b1);
    check("R5 match1 with clear off", 32'(match_o), 32'b10);
    check("R9 count at compare", 32'(count_o), 32'd5);
    step(1'b1, 1'b1);
    check("R9 count past compare", 32'(count_o), 32'd6);
    check("R6 irq1 after match", 32'(irq_o), 32'b10);

    // R7: compare 0 = 0 fires on the clear
    do_reset();
    wr(2'd0, 16'd0);
    wr(2'd1, 16'd2);
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    check("R7 reach compare1", 32'(match_o), 32'b10);
    step(1'b1, 1'b1);
    check("R7 clear count", 32'(count_o), 32'd0);
    check("R7 clear fires match0", 32'(match_o), 32'b01);

    // R7: compare 1 = 0 repeats the event on every tick
    do_reset();
    wr(2'd1, 16'd0);
    step(1'b1, 1'b1);
    check("R7 stuck at zero", 32'(count_o), 32'd0);
    check("R5 match1 at zero", 32'(match_o), 32'b10);

    // R11: address 3 ignored (clear-enable stays 1, compare 1 kept)
    do_reset();
    wr(2'd1, 16'd2);
    wr(2'd3, 16'd0);
    for (int k = 0; k < 3; k++) step(1'b1, 1'b1);
    check("R11 addr3 ignored", 32'(count_o), 32'd0);

    // R10 and R1 compare reset value: wrap with clear off
    do_reset();
    wr(2'd2, 16'd0);
    for (int k = 0; k < 65535; k++) begin
      @(negedge clk);
      cnt_tick = 1'b1;
      run_en   = 1'b1;
    end
    @(posedge clk);
    #1;
    check("R10 reach top", 32'(count_o), 32'hFFFF);
    check("R1 both compares reset 0xFFFF", 32'(match_o), 32'b11);
    step(1'b1, 1'b1);
    check("R10 wrap to zero", 32'(count_o), 32'd0);
    check("R4 no repeat after wrap", 32'(match_o), 32'b00);

    // R1: reset while running
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset count", 32'(count_o), 32'd0);
    check("R1 async reset irq", 32'(irq_o), 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule